// File: doc/BRIEF.md
# Six-Read Command Sequence Detector

This block sits beside an SRAM port and watches every access the host makes. A fixed chain of five read addresses, followed by a sixth read whose address picks one of four commands, asks the non-volatile memory controller to store the array, recall it, turn the automatic power-down store off, or turn it back on. The block turns a recognised chain into a single-cycle request pulse for the controller and keeps the automatic-store enable flag itself.

Each access is a read strobe or a write strobe plus an address, sampled on a rising clock edge. Any write, or any read that breaks the chain, throws away the progress made so far. While the controller reports busy, strobes are not looked at. Once a store or recall has been requested, a hold output stays high, and strobes stay ignored, until the controller's busy signal has gone high and then low again.

Top module: `nvcmd_detect`

## Requirements
- R1: A command is recognised only after five accepted reads whose address bits 14..2 equal, in this order, those of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, directly followed by the sixth accepted read.
- R2: The sixth read selects the command by its address bits 14..2: 0x8FC0 raises `store_req`, 0x4C63 raises `recall_req`, 0x8B45 raises `as_off_req`, 0x4B46 raises `as_on_req`; the chosen output is high for exactly one cycle, in the cycle after the edge that sampled the sixth read, and no two request outputs are ever high together.
- R3: Address bits outside 14..2 never affect matching; changing any bit inside 14..2 of one read of the chain prevents the command.
- R4: An accepted read that does not match the expected address discards the chain and no request is issued for it.
- R5: An accepted write at any address discards the chain, and no request is issued for it.
- R6: An accepted read that breaks the chain but matches the first address (0x4E38) counts as the first step of a new chain.
- R7: `autostore_on` is 1 after reset; it becomes 0 on the same edge that raises `as_off_req` and 1 on the same edge that raises `as_on_req`, and nothing else changes it.
- R8: Read and write strobes sampled while `ctl_busy` is 1 are ignored and leave the chain progress unchanged.
- R9: `cmd_hold` rises on the edge that raises `store_req` or `recall_req`; while it is 1 all strobes are ignored; it falls on the first edge at which `ctl_busy` is 0 after having been 1 on the previous edge.
- R10: After reset all request outputs and `cmd_hold` are 0 and the chain is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_stb | input | 1 | Read access in this cycle |
| wr_stb | input | 1 | Write access in this cycle (wins over rd_stb) |
| addr | input | ADDR_W (19) | Word address of the access |
| ctl_busy | input | 1 | Controller is carrying out a store or recall |
| store_req | output | 1 | One-cycle request: copy array to non-volatile cells |
| recall_req | output | 1 | One-cycle request: copy non-volatile cells to array |
| as_off_req | output | 1 | One-cycle request: automatic store disabled |
| as_on_req | output | 1 | One-cycle request: automatic store enabled |
| autostore_on | output | 1 | Current automatic-store enable flag |
| cmd_hold | output | 1 | Accesses blocked after a store or recall request |

## Verification
The chain position is never visible directly, so a wrong position only shows when a chain completes: a missing or spurious request pulse, or a pulse one chain late, appears in the cycle after the sixth read. The bench therefore drives complete chains after every kind of interruption (bad read, write, restart at the first address, busy, hold) and compares all six outputs with a behavioural model on every clock, so a flag or hold that drifts from the model is caught in the same cycle it changes.

// File: rtl/nvcmd_pkg.sv
// Shared constants for the six-read command detector.
// Assumes the key addresses fit in 16 bits and are distinct in the compared slice.
package nvcmd_pkg;
    localparam int KEY_W      = 16;
    localparam int PREFIX_LEN = 5;
    localparam int NUM_CMD    = 4;

    // Bit positions of the command vector
    localparam int IDX_STORE  = 0;
    localparam int IDX_RECALL = 1;
    localparam int IDX_AS_OFF = 2;
    localparam int IDX_AS_ON  = 3;

    // Prefix address for chain step i (order is behaviour)
    function automatic logic [KEY_W-1:0] prefix_key(input int i);
        case (i)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction

    // Terminal address for command index i
    function automatic logic [KEY_W-1:0] cmd_key(input int i);
        case (i)
            IDX_STORE:  return 16'h8FC0;
            IDX_RECALL: return 16'h4C63;
            IDX_AS_OFF: return 16'h8B45;
            default:    return 16'h4B46;
        endcase
    endfunction
endpackage

// File: rtl/nvcmd_addr_match.sv
// Address comparator bank: compares the selected address slice against every
// prefix key and every terminal key in parallel.
// Assumes CMP_HI < KEY_W and CMP_LO <= CMP_HI < ADDR_W - 1.
module nvcmd_addr_match
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CMP_HI = 14,
    parameter int CMP_LO = 2
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [PREFIX_LEN-1:0] pre_hit,
    output logic [NUM_CMD-1:0]    cmd_hit
);
    localparam int SLICE_W = CMP_HI - CMP_LO + 1;

    logic [SLICE_W-1:0] slice;
    logic               unused_bits;

    // Bits outside the compared window are deliberately dropped
    assign slice       = addr[CMP_HI:CMP_LO];
    assign unused_bits = ^{addr[ADDR_W-1:CMP_HI+1], addr[CMP_LO-1:0]};

    // One comparator per prefix step
    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_pre
        localparam logic [KEY_W-1:0] KEY = prefix_key(g);
        assign pre_hit[g] = (slice == KEY[CMP_HI:CMP_LO]);
    end

    // One comparator per command terminal
    for (genvar c = 0; c < NUM_CMD; c++) begin : g_cmd
        localparam logic [KEY_W-1:0] KEY = cmd_key(c);
        assign cmd_hit[c] = (slice == KEY[CMP_HI:CMP_LO]);
    end
endmodule

// File: rtl/nvcmd_seq_fsm.sv
// Chain tracker: counts how many prefix reads have been matched in a row and
// flags the terminal read. Assumes accept already excludes busy/held cycles.
module nvcmd_seq_fsm
    import nvcmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  is_wr,
    input  logic [PREFIX_LEN-1:0] pre_hit,
    input  logic [NUM_CMD-1:0]    cmd_hit,
    output logic [NUM_CMD-1:0]    fire
);
    localparam int STEP_W = $clog2(PREFIX_LEN + 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(PREFIX_LEN);

    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] step_nx;
    logic              cur_hit;
    logic              at_last;

    assign at_last = (step == STEP_LAST);

    // Select the comparator for the step expected next
    always_comb begin
        cur_hit = 1'b0;
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (step == STEP_W'(i)) cur_hit = pre_hit[i];
        end
    end

    // Next chain position for an accepted access
    always_comb begin
        step_nx = step;
        if (accept) begin
            if (is_wr) begin
                step_nx = '0;
            end else if (!at_last && cur_hit) begin
                step_nx = step + STEP_W'(1);
            end else if (pre_hit[0]) begin
                step_nx = STEP_W'(1);
            end else begin
                step_nx = '0;
            end
        end
    end

    // Terminal read at the end of a full prefix selects the command
    assign fire = (accept && !is_wr && at_last) ? cmd_hit : '0;

    // Chain position register
    always_ff @(posedge clk) begin
        if (!rst_n) step <= '0;
        else        step <= step_nx;
    end

    p_step_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step <= STEP_LAST);

    p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_wr) |=> (step == '0));

    p_idle_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(step));
endmodule

// File: rtl/nvcmd_ctrl.sv
// Output stage: registers the request pulses, keeps the automatic-store flag
// and the post-command hold. Assumes fire is one-hot or zero.
module nvcmd_ctrl
    import nvcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMD-1:0] fire,
    input  logic               busy,
    output logic [NUM_CMD-1:0] req,
    output logic               as_flag,
    output logic               hold
);
    logic busy_q;
    logic start_op;
    logic busy_done;

    assign start_op  = fire[IDX_STORE] | fire[IDX_RECALL];
    assign busy_done = busy_q & ~busy;

    // One-cycle request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) req <= '0;
        else        req <= fire;
    end

    // Automatic-store enable flag, enabled out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)                as_flag <= 1'b1;
        else if (fire[IDX_AS_OFF]) as_flag <= 1'b0;
        else if (fire[IDX_AS_ON])  as_flag <= 1'b1;
    end

    // Previous busy level for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Hold from store/recall request until the controller finishes
    always_ff @(posedge clk) begin
        if (!rst_n)         hold <= 1'b0;
        else if (start_op)  hold <= 1'b1;
        else if (busy_done) hold <= 1'b0;
    end

    p_off_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req[IDX_AS_OFF] |-> !as_flag);

    p_on_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req[IDX_AS_ON] |-> as_flag);

    p_hold_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req[IDX_STORE] || req[IDX_RECALL]) |-> hold);

    p_hold_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> ($past(busy) && !busy) || (!$past(busy) && $past(busy_q)));
endmodule

// File: rtl/nvcmd_detect.sv
// Top of the six-read command detector. Gates the access strobes with busy and
// hold, matches addresses, tracks the chain and drives the request outputs.
// Assumes one access per cycle; a write strobe wins over a read strobe.
module nvcmd_detect
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CMP_HI = 14,
    parameter int CMP_LO = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ctl_busy,
    output logic              store_req,
    output logic              recall_req,
    output logic              as_off_req,
    output logic              as_on_req,
    output logic              autostore_on,
    output logic              cmd_hold
);
    logic                  accept;
    logic [PREFIX_LEN-1:0] pre_hit;
    logic [NUM_CMD-1:0]    cmd_hit;
    logic [NUM_CMD-1:0]    fire;
    logic [NUM_CMD-1:0]    req;

    // Only strobes outside busy and hold take part
    assign accept = (rd_stb | wr_stb) & ~ctl_busy & ~cmd_hold;

    nvcmd_addr_match #(
        .ADDR_W (ADDR_W),
        .CMP_HI (CMP_HI),
        .CMP_LO (CMP_LO)
    ) u_match (
        .addr    (addr),
        .pre_hit (pre_hit),
        .cmd_hit (cmd_hit)
    );

    nvcmd_seq_fsm u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .is_wr   (wr_stb),
        .pre_hit (pre_hit),
        .cmd_hit (cmd_hit),
        .fire    (fire)
    );

    nvcmd_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .busy    (ctl_busy),
        .req     (req),
        .as_flag (autostore_on),
        .hold    (cmd_hold)
    );

    assign store_req  = req[IDX_STORE];
    assign recall_req = req[IDX_RECALL];
    assign as_off_req = req[IDX_AS_OFF];
    assign as_on_req  = req[IDX_AS_ON];

    p_one_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_req, recall_req, as_off_req, as_on_req}));

    p_request_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req || as_off_req || as_on_req)
            |-> ($past(rd_stb) && !$past(wr_stb) && !$past(ctl_busy)));
endmodule

// File: tb/sim_nvcmd_detect.sv
module sim_nvcmd_detect;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_stb = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ctl_busy = 1'b0;
    logic          store_req, recall_req, as_off_req, as_on_req;
    logic          autostore_on, cmd_hold;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // DUT pulse counters, sampled away from the edge
    int n_store = 0, n_recall = 0, n_off = 0, n_on = 0;

    logic [15:0] pk [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
    logic [15:0] ck [4] = '{16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46};

    always #5 clk = ~clk;

    nvcmd_detect u0 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr(addr), .ctl_busy(ctl_busy),
        .store_req(store_req), .recall_req(recall_req),
        .as_off_req(as_off_req), .as_on_req(as_on_req),
        .autostore_on(autostore_on), .cmd_hold(cmd_hold)
    );

    // Behavioural reference model
    int   m_step = 0;
    bit   m_pb = 0;
    bit   e_st = 0, e_rc = 0, e_off = 0, e_on = 0, e_flag = 1, e_hold = 0;

    function automatic int key13(input logic [AW-1:0] a);
        return int'((a >> 2) & 19'h1FFF);
    endfunction

    function automatic int kk(input logic [15:0] k);
        return int'((k >> 2) & 16'h1FFF);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_pb = 0;
            e_st = 0; e_rc = 0; e_off = 0; e_on = 0; e_flag = 1; e_hold = 0;
        end else begin
            bit acc;
            int a;
            acc = (rd_stb || wr_stb) && !ctl_busy && !e_hold;
            e_st = 0; e_rc = 0; e_off = 0; e_on = 0;
            a = key13(addr);
            if (acc) begin
                if (wr_stb) m_step = 0;
                else if (m_step == 5) begin
                    if (a == kk(ck[0])) e_st = 1;
                    if (a == kk(ck[1])) e_rc = 1;
                    if (a == kk(ck[2])) e_off = 1;
                    if (a == kk(ck[3])) e_on = 1;
                    m_step = (a == kk(pk[0])) ? 1 : 0;
                end else if (a == kk(pk[m_step])) m_step++;
                else m_step = (a == kk(pk[0])) ? 1 : 0;
            end
            if (e_st || e_rc) e_hold = 1;
            else if (m_pb && !ctl_busy) e_hold = 0;
            if (e_off) e_flag = 0;
            else if (e_on) e_flag = 1;
            m_pb = ctl_busy;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, plus pulse counting
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(store_req == e_st,    "R2 store_req",    store_req,  e_st);
            chk(recall_req == e_rc,   "R2 recall_req",   recall_req, e_rc);
            chk(as_off_req == e_off,  "R2 as_off_req",   as_off_req, e_off);
            chk(as_on_req == e_on,    "R2 as_on_req",    as_on_req,  e_on);
            chk(autostore_on == e_flag, "R7 autostore_on", autostore_on, e_flag);
            chk(cmd_hold == e_hold,   "R9 cmd_hold",     cmd_hold,   e_hold);
            n_store  += store_req;
            n_recall += recall_req;
            n_off    += as_off_req;
            n_on     += as_on_req;
        end
    end

    task automatic rd(input logic [AW-1:0] a);
        @(posedge clk); #1;
        rd_stb = 1; wr_stb = 0; addr = a;
    endtask

    task automatic wr(input logic [AW-1:0] a);
        @(posedge clk); #1;
        rd_stb = 0; wr_stb = 1; addr = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rd_stb = 0; wr_stb = 0;
        end
    endtask

    task automatic prefix(input int upto);
        for (int i = 0; i < upto; i++) rd(AW'(pk[i]));
    endtask

    task automatic chain(input int c);
        prefix(5);
        rd(AW'(ck[c]));
        idle(2);
    endtask

    task automatic release_busy();
        @(posedge clk); #1; rd_stb = 0; wr_stb = 0; ctl_busy = 1;
        @(posedge clk); #1; ctl_busy = 1;
        @(posedge clk); #1; ctl_busy = 0;
        idle(2);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk(!store_req && !recall_req && !as_off_req && !as_on_req, "R10 no request", 0, 0);
        chk(autostore_on == 1, "R10 flag", autostore_on, 1);
        chk(cmd_hold == 0, "R10 hold", cmd_hold, 0);
        // R10: empty chain - a terminal read alone does nothing
        rd(AW'(ck[0])); idle(2);
        chk(n_store == 0, "R10 empty chain", n_store, 0);

        // R1/R2: store chain, then hold
        chain(0);
        chk(n_store == 1, "R1 store chain", n_store, 1);
        chk(cmd_hold == 1, "R9 hold after store", cmd_hold, 1);
        // R9: recall chain while held is ignored
        chain(1);
        chk(n_recall == 0, "R9 ignored while held", n_recall, 0);
        release_busy();
        chk(cmd_hold == 0, "R9 hold released", cmd_hold, 0);
        chain(1);
        chk(n_recall == 1, "R2 recall chain", n_recall, 1);
        release_busy();

        // R3: don't-care bits disturbed outside 14..2
        for (int i = 0; i < 5; i++) rd({3'b101, pk[i] ^ 16'h8003});
        rd({3'b011, ck[2] ^ 16'h8002}); idle(2);
        chk(n_off == 1, "R3 masked bits ignored", n_off, 1);
        chk(autostore_on == 0, "R7 flag cleared", autostore_on, 0);
        // R3: a flipped bit inside the window breaks it
        prefix(3); rd(AW'(pk[3] ^ 16'h0004)); rd(AW'(pk[4])); rd(AW'(ck[3])); idle(2);
        chk(n_on == 0, "R3 compared bit matters", n_on, 0);
        chain(3);
        chk(n_on == 1 && autostore_on == 1, "R7 flag set", autostore_on, 1);

        // R4: wrong read mid-chain
        prefix(3); rd(19'h01234); rd(AW'(pk[3])); rd(AW'(pk[4])); rd(AW'(ck[2])); idle(2);
        chk(n_off == 1, "R4 bad read aborts", n_off, 1);
        // R4: wrong terminal then a correct terminal right after
        prefix(5); rd(19'h00000); rd(AW'(ck[2])); idle(2);
        chk(n_off == 1, "R4 bad terminal aborts", n_off, 1);

        // R5: write mid-chain, even at the expected address
        prefix(2); wr(AW'(pk[2])); rd(AW'(pk[2])); rd(AW'(pk[3])); rd(AW'(pk[4])); rd(AW'(ck[2])); idle(2);
        chk(n_off == 1, "R5 write aborts", n_off, 1);
        prefix(5); wr(AW'(ck[2])); idle(2);
        chk(n_off == 1, "R5 write as terminal", n_off, 1);

        // R6: restart at step two when the breaking read is the first key
        prefix(3); rd(AW'(pk[0])); rd(AW'(pk[1])); rd(AW'(pk[2])); rd(AW'(pk[3])); rd(AW'(pk[4]));
        rd(AW'(ck[2])); idle(2);
        chk(n_off == 2, "R6 restart at step two", n_off, 2);
        prefix(5); rd(AW'(pk[0])); prefix(5); rd(AW'(ck[3])); idle(2);
        s = n_on;
        chk(s == 2, "R6 restart after full prefix", s, 2);

        // R8: strobes ignored while busy
        prefix(2);
        @(posedge clk); #1; ctl_busy = 1; rd_stb = 1; addr = 19'h05555;
        @(posedge clk); #1; wr_stb = 1; rd_stb = 0;
        @(posedge clk); #1; ctl_busy = 0; wr_stb = 0;
        rd(AW'(pk[2])); rd(AW'(pk[3])); rd(AW'(pk[4])); rd(AW'(ck[2])); idle(2);
        chk(n_off == 3, "R8 busy strobes ignored", n_off, 3);
        chain(3);
        chk(autostore_on == 1, "R7 flag back on", autostore_on, 1);

        idle(2);
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule